// File: doc/BRIEF.md
# Word-Oriented Serial Peripheral Slave with Deep Queues

This block is the slave end of a four-wire serial peripheral link that moves 24-bit words between an external host and a local processing core. Each word goes both ways at once, most significant bit first. A ten-entry queue sits on each direction, so the local core services the link in bursts rather than once per word. Two level interrupts tell the core when to act: one when enough received words have built up, and one when the transmit queue has drained to a low mark.

The serial pins are first brought into the system-clock domain, and edges of the serial clock are then found there. For this to work, the serial clock period must be at least 12 system-clock periods. Select must go low a setup time before the first clock edge and stay low a hold time after the last one. The two mode inputs choose the clock idle level and the capture edge, and are changed only while select is high. A finished received word waits in a holding register before it is written into the receive queue. A transmit word is copied straight from the head of the transmit queue into the shift register.

Top module: `spi_word_slave`

## Requirements
- R1: In the cycle after a synchronous reset, both queue levels read 0, `rx_empty` is 1, `tx_full` is 0, `miso` is 0 and both sticky error flags are 0.
- R2: All four modes work: `cpol` is the idle level of `sck`, and `cpha`=0 captures on the leading edge (the edge leaving idle), while `cpha`=1 captures on the trailing edge. Each word is 24 bits, shifted MSB first, and transmit and receive happen together.
- R3: Each queue holds 10 words. While `tx_full` is 1, a `tx_push` is ignored. An `rx_pop` while `rx_empty` is 1 is ignored. No level ever exceeds 10.
- R4: Every complete received word enters the receive queue, and `rx_data` presents the words in arrival order. Popping with `rx_pop` advances to the next word.
- R5: A word that completes while the receive queue holds 10 words is dropped, and `rx_overrun` becomes 1 and stays 1 until reset. The queued words are not disturbed.
- R6: If the transmit queue is empty when a word is loaded for sending, that word goes out as all zeros, and `tx_underrun` becomes 1 and stays 1 until reset.
- R7: If `ss_n` rises before the 24th capture edge, the partial received word is discarded and the bit count restarts. A transmit word whose first bit was captured is consumed anyway.
- R8: `rx_irq` is 1 exactly when the receive level is at least `rx_thresh` (valid range 1 to 10). It follows the level one clock later.
- R9: `tx_irq` is 1 exactly when the transmit level is at most `tx_thresh`. It follows the level one clock later.
- R10: A transmit word is removed from its queue at the first capture edge of the word that carries it, so `tx_level` falls by one per word sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: capture on leading edge, 1: on trailing edge |
| ss_n | input | 1 | Slave select, active low |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host (registered) |
| tx_push | input | 1 | Write `tx_data` into transmit queue |
| tx_data | input | 24 | Word to send |
| tx_full | output | 1 | Transmit queue holds 10 words |
| tx_level | output | 4 | Transmit queue occupancy |
| tx_thresh | input | 4 | Transmit low-water mark |
| tx_irq | output | 1 | Transmit level at or below mark |
| tx_underrun | output | 1 | Sticky: a word was sent from an empty queue |
| rx_pop | input | 1 | Remove head of receive queue |
| rx_data | output | 24 | Head of receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 4 | Receive queue occupancy |
| rx_thresh | input | 4 | Receive high-water mark |
| rx_irq | output | 1 | Receive level at or above mark |
| rx_overrun | output | 1 | Sticky: a received word was dropped |

## Verification
The bench targets the places where the edge roles swap between modes. A design that picks the wrong capture edge for one `cpha` setting returns words shifted by one bit in that mode only. It also aborts a frame midway. A design that keeps the bit count across a select rise then misaligns every later word, and one that pushes the partial word grows the receive level. It fills the receive queue and sends one word more. A queue that wraps on overflow would corrupt the oldest word, which the pop-back comparison exposes. Sending from an empty queue must return zeros, not stale shift-register content. Threshold edges are checked word by word, so an off-by-one compare shows up as an interrupt one word early or late.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  // per-cycle events derived from the synchronized serial pins
  typedef struct packed {
    logic active;  // select asserted
    logic start;   // select just asserted
    logic sample;  // capture edge
    logic drive;   // launch edge
  } spi_evt_t;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 10,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_frontend.sv
module spi_frontend
  import spi_word_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cpol,
  input  logic     cpha,
  input  logic     ss_n,
  input  logic     sck,
  input  logic     mosi,
  output spi_evt_t evt,
  output logic     mosi_s
);
  logic [SYNC-1:0] sck_q, ss_q, mosi_q;
  logic            sck_d, ss_d;
  logic            sck_s, ss_s;
  logic            rise, fall, lead, trail;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      ss_q   <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
      ss_d   <= 1'b1;
    end else begin
      sck_q  <= {sck_q[SYNC-2:0], sck};
      ss_q   <= {ss_q[SYNC-2:0], ss_n};
      mosi_q <= {mosi_q[SYNC-2:0], mosi};
      sck_d  <= sck_q[SYNC-1];
      ss_d   <= ss_q[SYNC-1];
    end
  end

  assign sck_s  = sck_q[SYNC-1];
  assign ss_s   = ss_q[SYNC-1];
  assign mosi_s = mosi_q[SYNC-1];
  assign rise   = sck_s & ~sck_d;
  assign fall   = ~sck_s & sck_d;
  assign lead   = cpol ? fall : rise;
  assign trail  = cpol ? rise : fall;

  assign evt.active = ~ss_s;
  assign evt.start  = ss_d & ~ss_s;
  assign evt.sample = ~ss_s & (cpha ? trail : lead);
  assign evt.drive  = ~ss_s & (cpha ? lead : trail);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_word_pkg::*;
#(
  parameter int W = 24,
  localparam int CNT_W = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cpha,
  input  spi_evt_t     evt,
  input  logic         mosi_s,
  input  logic [W-1:0] tx_head,
  input  logic         tx_empty,
  output logic         tx_pop,
  output logic         underrun_p,
  output logic         miso,
  output logic         hold_valid,
  output logic [W-1:0] hold_word
);
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     tx_sr;
  logic [W-2:0]     rx_sr;
  logic             loaded_ok;

  assign miso = tx_sr[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      loaded_ok  <= 1'b0;
      tx_pop     <= 1'b0;
      underrun_p <= 1'b0;
      hold_valid <= 1'b0;
      hold_word  <= '0;
    end else begin
      tx_pop     <= 1'b0;
      underrun_p <= 1'b0;
      hold_valid <= 1'b0;
      if (!evt.active) begin
        cnt <= '0;
      end else if (evt.start && !cpha) begin
        cnt       <= '0;
        tx_sr     <= tx_empty ? '0 : tx_head;
        loaded_ok <= !tx_empty;
      end else begin
        if (evt.drive) begin
          if (cpha && cnt == '0) begin
            tx_sr     <= tx_empty ? '0 : tx_head;
            loaded_ok <= !tx_empty;
          end else if (cpha || cnt != '0) begin
            tx_sr <= {tx_sr[W-2:0], 1'b0};
          end
        end
        if (evt.sample) begin
          rx_sr <= {rx_sr[W-3:0], mosi_s};
          if (cnt == '0) begin
            tx_pop     <= loaded_ok;
            underrun_p <= !loaded_ok;
          end
          if (cnt == CNT_W'(W - 1)) begin
            cnt        <= '0;
            hold_word  <= {rx_sr, mosi_s};
            hold_valid <= 1'b1;
            if (!cpha) begin
              tx_sr     <= tx_empty ? '0 : tx_head;
              loaded_ok <= !tx_empty;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_word_slave.sv
module spi_word_slave
  import spi_word_pkg::*;
#(
  parameter int DW    = 24,
  parameter int DEPTH = 10,
  parameter int SYNC  = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             ss_n,
  input  logic             sck,
  input  logic             mosi,
  output logic             miso,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_data,
  output logic             tx_full,
  output logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  output logic             tx_irq,
  output logic             tx_underrun,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_data,
  output logic             rx_empty,
  output logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_thresh,
  output logic             rx_irq,
  output logic             rx_overrun
);
  spi_evt_t       evt;
  logic           mosi_s;
  logic [DW-1:0]  tx_head, hold_word;
  logic           tx_empty, tx_pop, underrun_p, hold_valid, rx_full;

  spi_frontend #(.SYNC(SYNC)) fe_i (
    .clk(clk), .rst(rst), .cpol(cpol), .cpha(cpha),
    .ss_n(ss_n), .sck(sck), .mosi(mosi), .evt(evt), .mosi_s(mosi_s)
  );

  spi_shifter #(.W(DW)) sh_i (
    .clk(clk), .rst(rst), .cpha(cpha), .evt(evt), .mosi_s(mosi_s),
    .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .underrun_p(underrun_p), .miso(miso),
    .hold_valid(hold_valid), .hold_word(hold_word)
  );

  word_fifo #(.W(DW), .DEPTH(DEPTH)) txq_i (
    .clk(clk), .rst(rst), .push(tx_push), .din(tx_data), .pop(tx_pop),
    .head(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  word_fifo #(.W(DW), .DEPTH(DEPTH)) rxq_i (
    .clk(clk), .rst(rst), .push(hold_valid), .din(hold_word), .pop(rx_pop),
    .head(rx_data), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq      <= 1'b0;
      rx_irq      <= 1'b0;
      tx_underrun <= 1'b0;
      rx_overrun  <= 1'b0;
    end else begin
      tx_irq      <= (tx_level <= tx_thresh);
      rx_irq      <= (rx_level >= rx_thresh);
      tx_underrun <= tx_underrun | underrun_p;
      rx_overrun  <= rx_overrun | (hold_valid & rx_full);
    end
  end
endmodule

// File: rtl/spi_word_slave_chk.sv
module spi_word_slave_chk #(
  parameter int DEPTH = 10,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_push,
  input logic             tx_full,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_thresh,
  input logic [LVL_W-1:0] rx_thresh,
  input logic             tx_irq,
  input logic             rx_irq,
  input logic             tx_underrun,
  input logic             rx_overrun
);
  p_tx_bound_r3: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LVL_W'(DEPTH));
  p_rx_bound_r3: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LVL_W'(DEPTH));
  p_full_push_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_full && tx_push) |=> (tx_level >= LVL_W'(DEPTH - 1)));
  p_rx_step_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rx_level <= $past(rx_level) + 1'b1 && rx_level + 1'b1 >= $past(rx_level)));
  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |=> rx_overrun);
  p_underrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> tx_underrun);
  p_rx_irq_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rx_irq == ($past(rx_level) >= $past(rx_thresh))));
  p_tx_irq_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tx_irq == ($past(tx_level) <= $past(tx_thresh))));
endmodule

bind spi_word_slave spi_word_slave_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .tx_push(tx_push), .tx_full(tx_full),
  .tx_level(tx_level), .rx_level(rx_level), .tx_thresh(tx_thresh),
  .rx_thresh(rx_thresh), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
);

// File: tb/spi_word_slave_tb.sv
module spi_word_slave_tb_top;
  localparam int DW = 24;
  localparam int DEPTH = 10;
  localparam int H = 8;

  logic clk = 0, rst = 1;
  logic cpol = 0, cpha = 0, ss_n = 1, sck = 0, mosi = 0;
  logic miso;
  logic tx_push = 0, rx_pop = 0;
  logic [DW-1:0] tx_data = '0, rx_data;
  logic tx_full, rx_empty, tx_irq, rx_irq, tx_underrun, rx_overrun;
  logic [3:0] tx_level, rx_level;
  logic [3:0] tx_thresh = 4'd4, rx_thresh = 4'd3;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] txq[$];
  logic [DW-1:0] rxq[$];

  always #10 clk = ~clk;

  spi_word_slave dut_i (
    .clk(clk), .rst(rst), .cpol(cpol), .cpha(cpha), .ss_n(ss_n), .sck(sck),
    .mosi(mosi), .miso(miso), .tx_push(tx_push), .tx_data(tx_data),
    .tx_full(tx_full), .tx_level(tx_level), .tx_thresh(tx_thresh),
    .tx_irq(tx_irq), .tx_underrun(tx_underrun), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_empty(rx_empty), .rx_level(rx_level),
    .rx_thresh(rx_thresh), .rx_irq(rx_irq), .rx_overrun(rx_overrun)
  );

  function automatic logic exp_rx_irq(int lvl, int thr);
    return lvl >= thr;
  endfunction
  function automatic logic exp_tx_irq(int lvl, int thr);
    return lvl <= thr;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(int m);
    cpol = m[1]; cpha = m[0]; sck = m[1];
    wait_clk(4);
  endtask

  task automatic push_word(logic [DW-1:0] d);
    tx_push = 1; tx_data = d;
    if (txq.size() < DEPTH) txq.push_back(d);
    wait_clk(1);
    tx_push = 0;
  endtask

  task automatic pop_word(output logic [DW-1:0] d);
    d = rx_data; rx_pop = 1;
    wait_clk(1);
    rx_pop = 0;
  endtask

  task automatic shift_bits(logic [DW-1:0] mo, int nbits, output logic [DW-1:0] mi);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        mosi = mo[DW-1-i]; wait_clk(H);
        mi[DW-1-i] = miso; sck = ~cpol; wait_clk(H); sck = cpol;
      end else begin
        sck = ~cpol; mosi = mo[DW-1-i]; wait_clk(H);
        mi[DW-1-i] = miso; sck = cpol; wait_clk(H);
      end
    end
  endtask

  task automatic begin_frame();
    ss_n = 0; wait_clk(H);
  endtask
  task automatic end_frame();
    wait_clk(H); ss_n = 1; wait_clk(12);
  endtask

  // one full word with model update and per-word checks (R2, R8, R9, R10)
  task automatic xfer(logic [DW-1:0] mo);
    logic [DW-1:0] mi, exp_mi;
    exp_mi = (txq.size() > 0) ? txq.pop_front() : '0;
    shift_bits(mo, DW, mi);
    if (rxq.size() < DEPTH) rxq.push_back(mo);
    check("R2 miso word", mi, exp_mi);
    check("R8 rx_irq", rx_irq, exp_rx_irq(rxq.size(), rx_thresh));
    check("R9 tx_irq", tx_irq, exp_tx_irq(txq.size(), tx_thresh));
    check("R10 tx_level", tx_level, txq.size());
  endtask

  task automatic drain_rx(string req);
    logic [DW-1:0] d;
    check({req, " rx_level"}, rx_level, rxq.size());
    while (rxq.size() > 0) begin
      pop_word(d);
      check({req, " rx_data"}, d, rxq.pop_front());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d, mi;
    void'($urandom(32'h5EED_0042));
    wait_clk(5);
    rst = 0;
    wait_clk(1);
    // R1 reset state
    check("R1 tx_level", tx_level, 0);
    check("R1 rx_level", rx_level, 0);
    check("R1 rx_empty", rx_empty, 1);
    check("R1 tx_full", tx_full, 0);
    check("R1 miso", miso, 0);
    check("R1 flags", {tx_underrun, rx_overrun}, 0);
    wait_clk(2);
    check("R9 tx_irq empty", tx_irq, 1);

    // R9 threshold crossing, R3 transmit full
    for (int i = 0; i < 5; i++) push_word(24'hA00000 + 24'(i));
    wait_clk(2);
    check("R9 tx_irq above mark", tx_irq, 0);
    for (int i = 5; i < 11; i++) push_word(24'hA00000 + 24'(i));
    wait_clk(2);
    check("R3 tx_level cap", tx_level, DEPTH);
    check("R3 tx_full", tx_full, 1);

    // R2 R4 R8: ten words in mode 0
    set_mode(0);
    begin_frame();
    for (int i = 0; i < DEPTH; i++) xfer(24'h5A0000 ^ 24'(i * 24'h01357));
    end_frame();
    drain_rx("R4");
    // R3 pop when empty
    rx_pop = 1; wait_clk(1); rx_pop = 0; wait_clk(1);
    check("R3 pop empty level", rx_level, 0);
    check("R3 pop empty flag", rx_empty, 1);

    // R2 each mode
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      push_word(24'hC30000 | 24'(m)); push_word(24'h800001 ^ 24'(m << 4));
      begin_frame();
      xfer(24'hF0F0F0 ^ 24'(m)); xfer(24'h000001 << m);
      end_frame();
      drain_rx("R2");
    end

    // R7 abort mid-word
    set_mode(3);
    push_word(24'h111111); push_word(24'h222222);
    begin_frame();
    shift_bits(24'hDEADBE, 9, mi);
    end_frame();
    void'(txq.pop_front());
    check("R7 partial dropped", rx_level, 0);
    check("R7 tx consumed", tx_level, 1);
    begin_frame(); xfer(24'h0BCDEF); end_frame();
    drain_rx("R7");

    // random mix
    for (int it = 0; it < 30; it++) begin
      int n;
      set_mode(int'($urandom % 4));
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) push_word(24'($urandom));
      begin_frame();
      for (int k = 0; k < n; k++) xfer(24'($urandom));
      end_frame();
      drain_rx("R4 random");
    end
    check("R6 no underrun yet", tx_underrun, 0);
    check("R5 no overrun yet", rx_overrun, 0);

    // R6 underrun
    set_mode(0);
    begin_frame(); xfer(24'h123456); end_frame();
    check("R6 underrun flag", tx_underrun, 1);
    drain_rx("R6");
    check("R6 underrun sticky", tx_underrun, 1);

    // R5 overrun
    set_mode(2);
    begin_frame();
    for (int i = 0; i < DEPTH + 1; i++) xfer(24'h900000 + 24'(i * 3));
    end_frame();
    check("R5 overrun flag", rx_overrun, 1);
    check("R5 level held", rx_level, DEPTH);
    drain_rx("R5");
    check("R5 overrun sticky", rx_overrun, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule